// File: doc/BRIEF.md
# SMBus Block-Access Register Slave

This block is a two-wire serial slave that keeps a small bank of eight-bit configuration registers and presents them as one parallel output vector. It supports only two kinds of transfer: a block write and a block read. Both always begin at register 0 and step upward one register per byte. The command code is never decoded. A write spends its first two bytes on a command code and a byte count, acknowledges both, and then discards them. A read opens with a count byte that equals the number of registers, and the register contents follow it.

SCL and SDA are oversampled with a faster system clock through a synchronizer. The slave pulls SDA low through an open-drain enable, so the pin is driven low or released and never driven high. The reset values of the registers are set by a parameter. A typical use is holding the control settings of a neighbouring block that a board controller programs at start-up.

Top module: `smbRegSlave`

## Requirements
- R1: While reset is asserted, and on its release, register i shows the byte `RESET_VALUES[8i+7:8i]` on `regsOut[8i+7:8i]`, and `sdaDriveLow` is 0.
- R2: The slave acknowledges an address byte only when its upper seven bits equal `DEV_ADDR` (default 0x69). The byte is 0xD2 for a write (bit 0 = 0) and 0xD3 for a read (bit 0 = 1). For any other address it gives no acknowledge and does not pull SDA low again until a new start condition.
- R3: In a write, the two bytes that follow the address (command code and byte count) are each acknowledged. Their values change no register.
- R4: The data bytes of a write are sent MSB first. They are stored into registers 0, 1, 2, … in strict order, and each byte is acknowledged.
- R5: A stop after any whole data byte ends the write. Registers already written keep their new values and the others keep their old ones.
- R6: A data byte interrupted by a stop or by a repeated start before its eighth bit changes no register.
- R7: Data bytes beyond the last register are acknowledged and ignored.
- R8: In a read, the slave first sends the byte `NUM_REGS` (7 by default). It then sends registers 0 upward, MSB first, and sends 0xFF for each byte requested past the last register.
- R9: A host NACK after a read byte ends transmission. SDA stays released, so further clocks read 0xFF, until the next stop or start.
- R10: When every SCL high and low phase lasts at least 6 system clock cycles, the slave changes `sdaDriveLow` and `regsOut` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pin |
| sdaIn | input | 1 | Serial data line as seen at the pin |
| sdaDriveLow | output | 1 | 1 enables the open-drain pull-down on SDA |
| regsOut | output | NUM_REGS*8 | Register bank, register i at bits 8i+7:8i |

## Verification
A wrong bit counter or state shows up at the ninth clock of the affected byte: the acknowledge is missing or lands on the wrong clock, or the slave holds SDA low during a data bit. A wrong register index shows up on `regsOut` as soon as the following stop, because a value lands in the neighbouring register. During a read it shows up in the byte sent straight after the count. A slave that keeps driving after a host NACK or a foreign address holds SDA low on the next clock, and the following byte reads as something other than 0xFF.

// File: rtl/smbRegPkg.sv
package smbRegPkg;

  // Synchronized bus events handed from the line sampler to the control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaNow;
  } lineEv_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic clrBits;
    logic shiftIn;
    logic store;
    logic clrIdx;
    logic incIdx;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } ctrlState_t;

endpackage

// File: rtl/smbLineSampler.sv
module smbLineSampler
  import smbRegPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  output lineEv_t ev
);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  // Idle bus lines are high, so every stage resets to 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_comb begin
    ev.sclRise   = sclNow & ~sclPrev;
    ev.sclFall   = ~sclNow & sclPrev;
    ev.startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
    ev.stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    ev.sdaNow    = sdaNow;
  end

endmodule

// File: rtl/smbSlaveData.sv
module smbSlaveData
  import smbRegPkg::*;
#(
  parameter int                      NUM_REGS     = 7,
  parameter logic [NUM_REGS*8-1:0]   RESET_VALUES = '0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               stb,
  input  logic                    sdaNow,
  output logic [7:0]              rxByte,
  output logic [3:0]              bitCnt,
  output logic                    txBit,
  output logic [NUM_REGS*8-1:0]   regsOut
);

  // Byte index: write uses 0,1 as preamble, 2.. as registers;
  // read uses 0 as the count byte, 1.. as registers.
  localparam int IDXW = $clog2(NUM_REGS + 3);
  localparam logic [IDXW-1:0] IDX_MAX = '1;

  logic [IDXW-1:0] idx;
  logic [7:0]      txShift;
  logic [7:0]      txSel;
  logic [7:0]      bank [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      bitCnt <= '0;
    end else if (stb.clrBits) begin
      bitCnt <= '0;
    end else if (stb.shiftIn && bitCnt != 4'd8) begin
      rxByte <= {rxByte[6:0], sdaNow};
      bitCnt <= bitCnt + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
    end else if (stb.clrIdx) begin
      idx <= '0;
    end else if (stb.incIdx && idx != IDX_MAX) begin
      idx <= idx + 1'b1;
    end
  end

  always_comb begin
    txSel = 8'hFF;
    if (idx == '0) begin
      txSel = 8'(NUM_REGS);
    end
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDXW'(i + 1)) txSel = bank[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= 8'hFF;
    end else if (stb.loadTx) begin
      txShift <= txSel;
    end else if (stb.shiftTx) begin
      txShift <= {txShift[6:0], 1'b1};
    end
  end

  assign txBit = txShift[7];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic hit;
    assign hit = stb.store && (idx == IDXW'(g + 2));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bank[g] <= RESET_VALUES[g*8 +: 8];
      end else if (hit) begin
        bank[g] <= rxByte;
      end
    end
    assign regsOut[g*8 +: 8] = bank[g];
  end

endmodule

// File: rtl/smbSlaveCtrl.sv
module smbSlaveCtrl
  import smbRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  lineEv_t    ev,
  input  logic [7:0] rxByte,
  input  logic [3:0] bitCnt,
  input  logic       txBit,
  output dpStrobe_t  stb,
  output logic       sdaDriveLow
);

  ctrlState_t state, stateN;
  logic ackLow, ackLowN;
  logic txOn, txOnN;
  logic dirRead, dirReadN;
  logic hostAck, hostAckN;
  logic byteFull;

  assign byteFull = (bitCnt == 4'd8);

  always_comb begin
    stb      = '0;
    stateN   = state;
    ackLowN  = ackLow;
    txOnN    = txOn;
    dirReadN = dirRead;
    hostAckN = hostAck;
    if (ev.startSeen) begin
      stateN      = ST_ADDR;
      stb.clrBits = 1'b1;
      stb.clrIdx  = 1'b1;
      ackLowN     = 1'b0;
      txOnN       = 1'b0;
    end else if (ev.stopSeen) begin
      stateN  = ST_IDLE;
      ackLowN = 1'b0;
      txOnN   = 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (ev.sclRise) begin
            stb.shiftIn = 1'b1;
          end else if (ev.sclFall && byteFull) begin
            stb.clrBits = 1'b1;
            if (rxByte[7:1] == DEV_ADDR) begin
              ackLowN  = 1'b1;
              dirReadN = rxByte[0];
              stateN   = ST_ADDR_ACK;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (ev.sclFall) begin
            ackLowN = 1'b0;
            if (dirRead) begin
              txOnN      = 1'b1;
              stb.loadTx = 1'b1;
              stb.incIdx = 1'b1;
              stateN     = ST_TX;
            end else begin
              stateN = ST_RX;
            end
          end
        end
        ST_RX: begin
          if (ev.sclRise) begin
            stb.shiftIn = 1'b1;
          end else if (ev.sclFall && byteFull) begin
            stb.store   = 1'b1;
            stb.incIdx  = 1'b1;
            stb.clrBits = 1'b1;
            ackLowN     = 1'b1;
            stateN      = ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (ev.sclFall) begin
            ackLowN = 1'b0;
            stateN  = ST_RX;
          end
        end
        ST_TX: begin
          if (ev.sclRise) begin
            stb.shiftIn = 1'b1;
          end else if (ev.sclFall) begin
            if (byteFull) begin
              stb.clrBits = 1'b1;
              txOnN       = 1'b0;
              stateN      = ST_TX_ACK;
            end else begin
              stb.shiftTx = 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (ev.sclRise) begin
            hostAckN = ~ev.sdaNow;
          end else if (ev.sclFall) begin
            if (hostAck) begin
              stb.loadTx = 1'b1;
              stb.incIdx = 1'b1;
              txOnN      = 1'b1;
              stateN     = ST_TX;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ackLow  <= 1'b0;
      txOn    <= 1'b0;
      dirRead <= 1'b0;
      hostAck <= 1'b0;
    end else begin
      state   <= stateN;
      ackLow  <= ackLowN;
      txOn    <= txOnN;
      dirRead <= dirReadN;
      hostAck <= hostAckN;
    end
  end

  assign sdaDriveLow = ackLow | (txOn & ~txBit);

endmodule

// File: rtl/smbRegSlave.sv
module smbRegSlave
  import smbRegPkg::*;
#(
  parameter int                    NUM_REGS     = 7,
  parameter logic [6:0]            DEV_ADDR     = 7'h69,
  parameter int                    SYNC_STAGES  = 2,
  parameter logic [NUM_REGS*8-1:0] RESET_VALUES = 56'h0F7700FFA55AC3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaDriveLow,
  output logic [NUM_REGS*8-1:0] regsOut
);

  lineEv_t   ev;
  dpStrobe_t stb;
  logic [7:0] rxByte;
  logic [3:0] bitCnt;
  logic       txBit;

  smbLineSampler #(.SYNC_STAGES(SYNC_STAGES)) uSampler (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ev(ev)
  );

  smbSlaveCtrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte), .bitCnt(bitCnt),
    .txBit(txBit), .stb(stb), .sdaDriveLow(sdaDriveLow)
  );

  smbSlaveData #(.NUM_REGS(NUM_REGS), .RESET_VALUES(RESET_VALUES)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaNow(ev.sdaNow), .rxByte(rxByte),
    .bitCnt(bitCnt), .txBit(txBit), .regsOut(regsOut)
  );

endmodule

// File: rtl/smbRegSlaveChk.sv
module smbRegSlaveChk #(
  parameter int                    NUM_REGS     = 7,
  parameter logic [NUM_REGS*8-1:0] RESET_VALUES = '0
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaDriveLow,
  input logic [NUM_REGS*8-1:0] regsOut,
  input logic                  startSeen,
  input logic                  stopSeen,
  input logic                  storeStb
);

  assert_reset_defaults_R1: assert property (@(posedge clk)
    $rose(rstN) |-> (regsOut == RESET_VALUES && !sdaDriveLow));

  assert_regs_need_store_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regsOut) |-> $past(storeStb));

  assert_regs_move_scl_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regsOut) |-> !sclIn);

  assert_no_store_on_condition_R6: assert property (@(posedge clk) disable iff (!rstN)
    (startSeen || stopSeen) |-> !storeStb);

  assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclIn);

endmodule

bind smbRegSlave smbRegSlaveChk #(
  .NUM_REGS(NUM_REGS), .RESET_VALUES(RESET_VALUES)
) chkInst (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow),
  .regsOut(regsOut), .startSeen(ev.startSeen), .stopSeen(ev.stopSeen),
  .storeStb(stb.store)
);

// File: tb/tb_smbRegSlave.sv
module tb_smbRegSlave;

  localparam int NREG = 7;
  localparam logic [NREG*8-1:0] DEFAULTS = 56'h0F7700FFA55AC3;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclReg = 1'b1;
  logic hostSda = 1'b1;
  logic sdaDriveLow;
  logic [NREG*8-1:0] regsOut;
  logic sdaLine;

  assign sdaLine = hostSda & ~sdaDriveLow;
  always #10 clk = ~clk;

  smbRegSlave #(
    .NUM_REGS(NREG), .DEV_ADDR(7'h69), .SYNC_STAGES(2), .RESET_VALUES(DEFAULTS)
  ) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclReg), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .regsOut(regsOut)
  );

  int nChecks = 0;
  int nFails = 0;
  int sclHighMoves = 0;
  logic prevDrive = 1'b0;
  logic [7:0] model [NREG];
  logic [7:0] wbuf [16];

  // R10 monitor: slave pin activity while SCL is high
  always @(negedge clk) begin
    if (rstN && sclReg && (sdaDriveLow != prevDrive)) sclHighMoves++;
    prevDrive = sdaDriveLow;
  end

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  function automatic logic [NREG*8-1:0] modelVec();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  function automatic logic [7:0] expRead(int k);
    return (k < NREG) ? model[k] : 8'hFF;
  endfunction

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    hostSda = 1'b1; waitQ();
    sclReg = 1'b1;  waitQ();
    hostSda = 1'b0; waitQ();
    sclReg = 1'b0;  waitQ();
  endtask

  task automatic busStop();
    hostSda = 1'b0; waitQ();
    sclReg = 1'b1;  waitQ();
    hostSda = 1'b1; waitQ();
  endtask

  task automatic clockBit(input logic bitv, output logic smp);
    hostSda = bitv; waitQ();
    sclReg = 1'b1;  waitQ();
    smp = sdaLine;  waitQ();
    sclReg = 1'b0;  waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackd);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    ackd = ~s;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      b[i] = s;
    end
    clockBit(~ackIt, s);
  endtask

  task automatic writeTxn(input int n);
    logic a;
    busStart();
    sendByte(8'hD2, a); check(a, "R2 write address ack", 64'(a), 64'd1);
    sendByte(8'($urandom), a); check(a, "R3 command ack", 64'(a), 64'd1);
    sendByte(8'($urandom), a); check(a, "R3 count ack", 64'(a), 64'd1);
    for (int k = 0; k < n; k++) begin
      sendByte(wbuf[k], a);
      if (k < NREG) begin
        check(a, "R4 data ack", 64'(a), 64'd1);
        model[k] = wbuf[k];
      end else begin
        check(a, "R7 extra byte ack", 64'(a), 64'd1);
      end
    end
    busStop();
    check(regsOut == modelVec(), "R5 R7 registers after write", 64'(regsOut), 64'(modelVec()));
  endtask

  task automatic readTxn(input int n);
    logic a;
    logic [7:0] b;
    busStart();
    sendByte(8'hD3, a); check(a, "R2 read address ack", 64'(a), 64'd1);
    recvByte(n > 0, b); check(b == 8'd7, "R8 count byte", 64'(b), 64'd7);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, b);
      check(b == expRead(k), "R8 read data", 64'(b), 64'(expRead(k)));
    end
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finishRun();
  end

  initial begin
    logic a;
    logic s;
    logic [7:0] b;
    void'($urandom(32'd4711));
    for (int i = 0; i < NREG; i++) model[i] = DEFAULTS[i*8 +: 8];
    repeat (4) @(negedge clk);
    // R1: state held during reset
    check(regsOut == DEFAULTS, "R1 defaults in reset", 64'(regsOut), 64'(DEFAULTS));
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(regsOut == DEFAULTS, "R1 defaults after reset", 64'(regsOut), 64'(DEFAULTS));
    check(sdaDriveLow == 1'b0, "R1 SDA released", 64'(sdaDriveLow), 64'd0);

    // R2: foreign address, then more bytes before any new start
    busStart();
    sendByte(8'hA4, a); check(!a, "R2 foreign address nack", 64'(a), 64'd0);
    sendByte(8'h00, a); check(!a, "R2 idle after mismatch", 64'(a), 64'd0);
    sendByte(8'hD2, a); check(!a, "R2 no ack without start", 64'(a), 64'd0);
    busStop();
    check(regsOut == modelVec(), "R2 registers untouched", 64'(regsOut), 64'(modelVec()));

    // R3 R4: full write with arbitrary preamble bytes
    for (int k = 0; k < NREG; k++) wbuf[k] = 8'(8'h11 * (k + 1));
    writeTxn(NREG);
    readTxn(NREG + 2);  // R8: includes two bytes past the bank

    // R5: stop after three bytes
    for (int k = 0; k < 3; k++) wbuf[k] = 8'(8'hE0 + k);
    writeTxn(3);

    // R7: overlong write
    for (int k = 0; k < 10; k++) wbuf[k] = 8'(8'h40 + k);
    writeTxn(10);

    // R6: byte cut short by stop
    busStart();
    sendByte(8'hD2, a); sendByte(8'h00, a); sendByte(8'h00, a);
    for (int i = 0; i < 4; i++) clockBit(1'b1, s);
    busStop();
    check(regsOut == modelVec(), "R6 partial byte then stop", 64'(regsOut), 64'(modelVec()));

    // R6: byte cut short by repeated start
    busStart();
    sendByte(8'hD2, a); sendByte(8'h00, a); sendByte(8'h00, a);
    sendByte(8'h9C, a); model[0] = 8'h9C;
    for (int i = 0; i < 5; i++) clockBit(1'b0, s);
    busStart();
    busStop();
    check(regsOut == modelVec(), "R6 partial byte then restart", 64'(regsOut), 64'(modelVec()));

    // R9: host NACK ends the read
    busStart();
    sendByte(8'hD3, a);
    recvByte(1'b1, b);
    recvByte(1'b0, b); check(b == model[0], "R9 byte before nack", 64'(b), 64'(model[0]));
    recvByte(1'b0, b); check(b == 8'hFF, "R9 released after nack", 64'(b), 64'hFF);
    check(sdaDriveLow == 1'b0, "R9 not driving", 64'(sdaDriveLow), 64'd0);
    busStop();

    // Random write lengths and data, each verified by a full read
    for (int it = 0; it < 12; it++) begin
      int n;
      n = int'($urandom_range(0, 10));
      for (int k = 0; k < 16; k++) wbuf[k] = 8'($urandom);
      writeTxn(n);
      readTxn(NREG);
    end

    check(sclHighMoves == 0, "R10 SDA changes only with SCL low", 64'(sclHighMoves), 64'd0);
    finishRun();
  end

endmodule